// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block places a 32x32 pixel cursor on top of an RGB15 pixel stream on its way to the display. Each cursor pixel is a 16-bit word held in a local bitmap store. The store covers exactly one 2 KiB region of 1024 words and is loaded through a simple write port. The word picks the pixel's treatment by itself. An opaque word replaces the pixel with a colour. One fixed pattern inverts the underlying pixel. Zero, and every other word with the top bit clear, leaves the pixel alone.

The beam coordinates travel alongside each pixel. The block compares them against the active cursor position and reads the matching bitmap word. It then emits the chosen pixel one cycle later, with both sync signals delayed by the same cycle. Position updates are guarded so that the cursor never tears. A new position written while the beam is drawing rows of the old or the new cursor area is held back. It takes effect once the beam is past both areas, or during vertical blanking.

Top module: `cursor_overlay`

## Requirements
- R1: `pix_o`, `hsync_o` and `vsync_o` are registered and show the result for the inputs of the previous clock cycle, so the overlay adds exactly one cycle of latency to the pixel and to both syncs.
- R2: A bitmap word of 0x0000 under the beam passes the input pixel through unchanged.
- R3: A bitmap word with bit 15 set outputs its bits 14:0 as the pixel (0xFFFF gives 0x7FFF white, 0x8000 gives 0x0000 black).
- R4: A bitmap word of 0x7FFF outputs the bitwise inverse of the 15-bit input pixel.
- R5: Any other nonzero bitmap word with bit 15 clear is transparent and passes the input pixel through.
- R6: The cursor covers beam X from pos_x to pos_x+31 and beam Y from pos_y to pos_y+31. Beam pixel (pos_x+c, pos_y+r) uses bitmap word r*32+c, the word index written on `bmp_addr_i`. Outside this area the input pixel passes through.
- R7: The position word carries X in bits 11:0 and Y in bits 27:16; bits 15:12 and 31:28 are ignored.
- R8: While `cur_en_i` is low, every pixel passes through unchanged.
- R9: A position write takes effect from the next cycle when the beam Y at the write lies outside both the current and the new cursor row span.
- R10: A position write made while the beam Y lies in the current or the new row span is held pending. It becomes active after the first later cycle in which `vblank_i` is high or beam Y is at least max(current Y, pending Y)+32. A newer write replaces a pending one.
- R11: After reset the outputs are 0, the active position is (0,0) and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_en_i | input | 1 | Cursor enable |
| bmp_we_i | input | 1 | Bitmap word write strobe |
| bmp_addr_i | input | 10 | Bitmap word index (row*32+column) |
| bmp_data_i | input | 16 | Bitmap word to write |
| pos_we_i | input | 1 | Position write strobe |
| pos_data_i | input | 32 | Position word: X in 11:0, Y in 27:16 |
| beam_x_i | input | 12 | Beam column of the current pixel |
| beam_y_i | input | 12 | Beam line of the current pixel |
| vblank_i | input | 1 | Vertical blanking indicator |
| pix_i | input | 15 | Underlying RGB15 pixel |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| pix_o | output | 15 | Overlaid RGB15 pixel |
| hsync_o | output | 1 | Horizontal sync, delayed one cycle |
| vsync_o | output | 1 | Vertical sync, delayed one cycle |

## Verification
The hardest case to reach is a deferred position update, where the pending position must stay hidden while the beam wanders through rows. The bench writes positions while the beam sits inside the old rows, then inside only the new rows. It steps the beam to just below and exactly at the release line, and separately releases a pending write with a blanking cycle. Each cycle's output shows which position is active. The scoreboard model tracks the active and pending positions from the requirements alone, so every pixel shows whether the update landed in the right cycle.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int unsigned CUR_PW = 15;
  localparam int unsigned CUR_WW = CUR_PW + 1;
  localparam logic [CUR_WW-1:0] CUR_INV_WORD = {1'b0, {CUR_PW{1'b1}}};

  function automatic logic [CUR_PW-1:0] cur_mix(logic [CUR_WW-1:0] w, logic [CUR_PW-1:0] p);
    if (w[CUR_WW-1])            return w[CUR_PW-1:0];
    else if (w == CUR_INV_WORD) return ~p;
    else                        return p;
  endfunction
endpackage

// File: rtl/cursor_bitmap_ram.sv
module cursor_bitmap_ram #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [WW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [WW-1:0] rd_o
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  assign rd_o = mem[ra_i];
endmodule

// File: rtl/cursor_pos_ctrl.sv
module cursor_pos_ctrl #(
  parameter int unsigned CW  = 12,
  parameter int unsigned DIM = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] new_x_i,
  input  logic [CW-1:0] new_y_i,
  input  logic [CW-1:0] beam_y_i,
  input  logic          vblank_i,
  output logic [CW-1:0] act_x_o,
  output logic [CW-1:0] act_y_o,
  output logic          pend_o
);
  logic [CW-1:0] pend_x, pend_y;

  function automatic logic in_rows(logic [CW-1:0] y, logic [CW-1:0] base);
    return (y >= base) && ({1'b0, y} < ({1'b0, base} + (CW+1)'(DIM)));
  endfunction

  logic          busy_now;
  logic [CW-1:0] hi_y;
  logic          past_both;

  assign busy_now  = in_rows(beam_y_i, act_y_o) || in_rows(beam_y_i, new_y_i);
  assign hi_y      = (pend_y > act_y_o) ? pend_y : act_y_o;
  assign past_both = {1'b0, beam_y_i} >= ({1'b0, hi_y} + (CW+1)'(DIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_x_o <= '0;
      act_y_o <= '0;
      pend_x  <= '0;
      pend_y  <= '0;
      pend_o  <= 1'b0;
    end else if (we_i) begin
      if (busy_now) begin
        pend_x <= new_x_i;
        pend_y <= new_y_i;
        pend_o <= 1'b1;
      end else begin
        act_x_o <= new_x_i;
        act_y_o <= new_y_i;
        pend_o  <= 1'b0;
      end
    end else if (pend_o && (vblank_i || past_both)) begin
      act_x_o <= pend_x;
      act_y_o <= pend_y;
      pend_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/cursor_pixel_mix.sv
module cursor_pixel_mix
  import cursor_pkg::*;
#(
  parameter int unsigned CW  = 12,
  parameter int unsigned DIM = 32,
  localparam int unsigned IW = $clog2(DIM)
) (
  input  logic              en_i,
  input  logic [CW-1:0]     beam_x_i,
  input  logic [CW-1:0]     beam_y_i,
  input  logic [CW-1:0]     act_x_i,
  input  logic [CW-1:0]     act_y_i,
  input  logic [CUR_PW-1:0] pix_i,
  output logic [2*IW-1:0]   rd_addr_o,
  input  logic [CUR_WW-1:0] rd_word_i,
  output logic [CUR_PW-1:0] pix_o
);
  logic [CW-1:0] dx, dy;
  logic          hit;

  assign dx  = beam_x_i - act_x_i;
  assign dy  = beam_y_i - act_y_i;
  assign hit = en_i && (beam_x_i >= act_x_i) && (dx < CW'(DIM))
                    && (beam_y_i >= act_y_i) && (dy < CW'(DIM));

  assign rd_addr_o = {dy[IW-1:0], dx[IW-1:0]};
  assign pix_o     = hit ? cur_mix(rd_word_i, pix_i) : pix_i;
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int unsigned CW  = 12,
  parameter int unsigned DIM = 32,
  localparam int unsigned IW = $clog2(DIM),
  localparam int unsigned AW = 2 * IW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cur_en_i,
  input  logic              bmp_we_i,
  input  logic [AW-1:0]     bmp_addr_i,
  input  logic [CUR_WW-1:0] bmp_data_i,
  input  logic              pos_we_i,
  input  logic [31:0]       pos_data_i,
  input  logic [CW-1:0]     beam_x_i,
  input  logic [CW-1:0]     beam_y_i,
  input  logic              vblank_i,
  input  logic [CUR_PW-1:0] pix_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  output logic [CUR_PW-1:0] pix_o,
  output logic              hsync_o,
  output logic              vsync_o
);
  logic [CW-1:0]     act_x, act_y;
  logic              pend_v;
  logic [AW-1:0]     rd_addr;
  logic [CUR_WW-1:0] rd_word;
  logic [CUR_PW-1:0] mixed;
  logic              unused_pos_bits;

  assign unused_pos_bits = ^{pos_data_i[31:16+CW], pos_data_i[15:CW]};

  cursor_bitmap_ram #(.DEPTH(DIM*DIM), .WW(CUR_WW)) i_ram (
    .clk_i (clk_i),
    .we_i  (bmp_we_i),
    .wa_i  (bmp_addr_i),
    .wd_i  (bmp_data_i),
    .ra_i  (rd_addr),
    .rd_o  (rd_word)
  );

  cursor_pos_ctrl #(.CW(CW), .DIM(DIM)) i_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pos_we_i),
    .new_x_i  (pos_data_i[CW-1:0]),
    .new_y_i  (pos_data_i[16+CW-1:16]),
    .beam_y_i (beam_y_i),
    .vblank_i (vblank_i),
    .act_x_o  (act_x),
    .act_y_o  (act_y),
    .pend_o   (pend_v)
  );

  cursor_pixel_mix #(.CW(CW), .DIM(DIM)) i_mix (
    .en_i      (cur_en_i),
    .beam_x_i  (beam_x_i),
    .beam_y_i  (beam_y_i),
    .act_x_i   (act_x),
    .act_y_i   (act_y),
    .pix_i     (pix_i),
    .rd_addr_o (rd_addr),
    .rd_word_i (rd_word),
    .pix_o     (mixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      pix_o   <= mixed;
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int unsigned CW  = 12,
  parameter int unsigned DIM = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cur_en_i,
  input logic          pos_we_i,
  input logic [CW-1:0] beam_y_i,
  input logic          vblank_i,
  input logic [14:0]   pix_i,
  input logic          hsync_i,
  input logic          vsync_i,
  input logic [14:0]   pix_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic [CW-1:0] act_x,
  input logic [CW-1:0] act_y,
  input logic          pend_v
);
  logic in_act_rows;
  assign in_act_rows = (beam_y_i >= act_y) && ({1'b0, beam_y_i} < ({1'b0, act_y} + (CW+1)'(DIM)));

  p_sync_delay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hsync_o == $past(hsync_i)) && (vsync_o == $past(vsync_i)));

  p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_en_i |=> pix_o == $past(pix_i));

  p_no_tear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_act_rows && !vblank_i) |=> $stable(act_x) && $stable(act_y));

  p_vblank_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v && vblank_i && !pos_we_i) |=> !pend_v);
endmodule

bind cursor_overlay cursor_overlay_chk #(.CW(CW), .DIM(DIM)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cur_en_i (cur_en_i),
  .pos_we_i (pos_we_i),
  .beam_y_i (beam_y_i),
  .vblank_i (vblank_i),
  .pix_i    (pix_i),
  .hsync_i  (hsync_i),
  .vsync_i  (vsync_i),
  .pix_o    (pix_o),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .act_x    (act_x),
  .act_y    (act_y),
  .pend_v   (pend_v)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cur_en_i = 1'b0;
  logic        bmp_we_i = 1'b0;
  logic [9:0]  bmp_addr_i = '0;
  logic [15:0] bmp_data_i = '0;
  logic        pos_we_i = 1'b0;
  logic [31:0] pos_data_i = '0;
  logic [11:0] beam_x_i = '0;
  logic [11:0] beam_y_i = 12'd2000;
  logic        vblank_i = 1'b0;
  logic [14:0] pix_i = '0;
  logic        hsync_i = 1'b0;
  logic        vsync_i = 1'b0;
  logic [14:0] pix_o;
  logic        hsync_o, vsync_o;

  always #10 clk_i = ~clk_i;

  cursor_overlay i_cursor_overlay (.*);

  int checks = 0, errors = 0;
  logic [15:0] bmp [1024];
  logic [16:0] exp_q [$];
  string       tag_q [$];

  int  m_ax = 0, m_ay = 0, m_px = 0, m_py = 0;
  bit  m_pv = 0;
  bit  wr = 0;
  int  wr_x = 0, wr_y = 0;

  function automatic logic [15:0] pat(int r, int c);
    if (r == 0  && c == 0)  return 16'hFFFF;
    if (r == 0  && c == 31) return 16'h8000;
    if (r == 31 && c == 0)  return 16'h7FFF;
    if (r == 31 && c == 31) return 16'h1234;
    if (r == 5  && c == 7)  return 16'h83E0;
    if (r == 2)             return 16'h8000 | 16'(c * 1000);
    if (r == 3)             return 16'h4000 | 16'(c);
    if (r == 10 && c < 4)   return 16'h7FFF;
    return 16'h0000;
  endfunction

  function automatic bit in_rows(int y, int base);
    return (y >= base) && (y < base + 32);
  endfunction

  task automatic drive(int x, int y, bit vb, string tag);
    logic [14:0] p, e;
    logic [15:0] w;
    bit hs, vs;
    @(negedge clk_i);
    p = 15'(x * 7 + y * 13) ^ 15'h2AAA;
    hs = x[0] ^ y[0];
    vs = y[3];
    beam_x_i = 12'(x); beam_y_i = 12'(y); vblank_i = vb;
    pix_i = p; hsync_i = hs; vsync_i = vs;
    pos_we_i = wr;
    pos_data_i = {4'hA, 12'(wr_y), 4'h5, 12'(wr_x)};
    e = p;
    if (cur_en_i && x >= m_ax && x < m_ax + 32 && y >= m_ay && y < m_ay + 32) begin
      w = bmp[(y - m_ay) * 32 + (x - m_ax)];
      if (w[15]) e = w[14:0];
      else if (w == 16'h7FFF) e = ~p;
    end
    exp_q.push_back({hs, vs, e});
    tag_q.push_back(tag);
    if (wr) begin
      if (in_rows(y, m_ay) || in_rows(y, wr_y)) begin
        m_px = wr_x; m_py = wr_y; m_pv = 1;
      end else begin
        m_ax = wr_x; m_ay = wr_y; m_pv = 0;
      end
    end else if (m_pv && (vb || y >= ((m_py > m_ay) ? m_py : m_ay) + 32)) begin
      m_ax = m_px; m_ay = m_py; m_pv = 0;
    end
    wr = 0;
  endtask

  task automatic write_pos(int x, int y, int bx, int by, string tag);
    wr = 1; wr_x = x; wr_y = y;
    drive(bx, by, 0, tag);
  endtask

  initial begin : monitor
    logic [16:0] e;
    string t;
    forever begin
      @(posedge clk_i); #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({hsync_o, vsync_o, pix_o} !== e) begin
          errors++;
          $display("FAIL %s: got {hs,vs,pix}=%h expected %h", t, {hsync_o, vsync_o, pix_o}, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk_i);
    checks++; // R11 reset state
    if ({hsync_o, vsync_o, pix_o} !== 17'h0) begin
      errors++;
      $display("FAIL R11: got %h expected 0", {hsync_o, vsync_o, pix_o});
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk_i);
      bmp[i] = pat(i / 32, i % 32);
      bmp_we_i = 1'b1; bmp_addr_i = 10'(i); bmp_data_i = bmp[i];
    end
    @(negedge clk_i);
    bmp_we_i = 1'b0;
    cur_en_i = 1'b1;
    drive(0, 0, 0, "R11");            // reset position (0,0) shows word 0
    drive(31, 0, 0, "R11");
    drive(3, 1, 0, "R1");
    drive(4, 2, 0, "R1");
    // R7/R9: immediate write, junk in ignored bits
    write_pos(100, 50, 0, 500, "R9");
    drive(100, 50, 0, "R9");
    drive(131, 50, 0, "R3");
    drive(100, 81, 0, "R4");
    drive(131, 81, 0, "R5");
    drive(101, 51, 0, "R2");
    drive(107, 55, 0, "R3");
    for (int c = 0; c < 32; c++) drive(100 + c, 52, 0, "R3");
    for (int c = 0; c < 32; c++) drive(100 + c, 53, 0, "R5");
    drive(99, 50, 0, "R6");
    drive(132, 50, 0, "R6");
    drive(100, 49, 0, "R6");
    drive(100, 82, 0, "R6");
    drive(131, 52, 0, "R7");
    // R8 disable
    @(negedge clk_i); cur_en_i = 1'b0;
    drive(100, 50, 0, "R8");
    drive(100, 81, 0, "R8");
    @(negedge clk_i); cur_en_i = 1'b1;
    drive(100, 50, 0, "R8");
    // R10: write inside old rows
    write_pos(200, 300, 100, 60, "R10");
    drive(100, 60, 0, "R10");
    drive(103, 60, 0, "R10");
    drive(200, 300, 0, "R10");
    drive(5, 331, 0, "R10");
    drive(200, 300, 0, "R10");
    drive(5, 332, 0, "R10");
    drive(200, 300, 0, "R10");
    drive(231, 300, 0, "R10");
    // R10: write inside new rows only, release by blanking
    write_pos(10, 10, 500, 20, "R10");
    drive(200, 300, 0, "R10");
    drive(10, 10, 0, "R10");
    drive(0, 900, 1, "R10");
    drive(10, 10, 0, "R10");
    drive(200, 300, 0, "R10");
    // R10: newer write replaces pending
    write_pos(400, 400, 12, 15, "R10");
    write_pos(600, 600, 12, 15, "R10");
    drive(0, 1000, 1, "R10");
    drive(400, 400, 0, "R10");
    drive(600, 600, 0, "R10");
    // R9: write outside both spans
    write_pos(0, 0, 0, 1000, "R9");
    drive(0, 0, 0, "R9");
    drive(600, 600, 0, "R9");
    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule